// File: doc/BRIEF.md
# Incrementing-Burst Memory Target

This block is an AXI4 target that serves bursts from a small internal word store. The read side and the write side are separate state machines that run at the same time. Each machine holds its address-channel ready high while it is idle. After one address handshake it works through a single burst, then returns to idle. There is never more than one outstanding transaction per direction, and the block has no transaction IDs.

The block serves only incrementing bursts in which every beat uses the full bus width and starts on a word boundary. The word index advances by one for each beat and wraps at the top of the store. The write burst length comes from WLAST and not from a length field. A request with the wrong size, a misaligned address or a non-incrementing burst type still completes its full handshake, so the master never stalls. Such a request leaves the store unchanged, answers with an error response and sets a sticky error flag.

Top module: `axi_burst_mem`

## Requirements
- R1: While `rst_n` is low, `arready`, `awready`, `rvalid`, `wready`, `bvalid` and `req_err` are all low. One cycle after reset is released, `arready` and `awready` are both high. On the write side, at most one of `awready`, `wready` and `bvalid` is high at any time.
- R2: A read address handshake (`arvalid` and `arready` high at a clock edge) drops `arready` and raises `rvalid` in the next cycle. A write address handshake drops `awready` and raises `wready` in the next cycle.
- R3: A read burst returns `arlen`+1 beats. Beat k carries the word at word index (`araddr`>>2)+k modulo 64. `rlast` is high on the final beat only.
- R4: Once `rvalid` is high, it stays high with `rlast` and `rresp` unchanged until `rready` is seen.
- R5: The cycle after the handshake on the beat with `rlast` high, `rvalid` is low and `arready` is high.
- R6: Each write beat taken (`wvalid` and `wready` high) updates the word at index (`awaddr`>>2)+k modulo 64. Only bytes whose `wstrb` bit is set change, with bit i covering `wdata[8i+7:8i]`.
- R7: The cycle after the beat with `wlast` high, `wready` is low and `bvalid` is high. `bvalid` and `bresp` hold until `bready` is seen. In the next cycle `bvalid` is low and `awready` is high.
- R8: A request whose size code (beat bytes = 2^size) is not 2 (full 32-bit width) is rejected. A rejected read returns zero data with `rresp` = 2'b10 on every beat. A rejected write changes no memory and ends with `bresp` = 2'b10. A legal request answers 2'b00.
- R9: A request whose address has bits [1:0] not zero is rejected in the same way as in R8.
- R10: A request whose burst code is not 2'b01 (incrementing) is rejected in the same way as in R8. This includes 2'b00 and 2'b10.
- R11: `req_err` goes high after any rejected address handshake. It stays high through later legal traffic until reset.
- R12: A read burst and a write burst to disjoint words can proceed in the same cycles without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| awaddr | input | ADDR_W | Write byte address |
| awsize | input | 3 | Write beat size code |
| awburst | input | 2 | Write burst type code |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| wdata | input | DATA_W | Write data |
| wstrb | input | DATA_W/8 | Write byte enables |
| wlast | input | 1 | Final write beat |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| bresp | output | 2 | Write response code |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| araddr | input | ADDR_W | Read byte address |
| arlen | input | LEN_W | Read beats minus one |
| arsize | input | 3 | Read beat size code |
| arburst | input | 2 | Read burst type code |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| rdata | output | DATA_W | Read data |
| rresp | output | 2 | Read response code |
| rlast | output | 1 | Final read beat |
| req_err | output | 1 | Sticky rejected-request flag |

## Verification
The bench targets these corner cases:

- **Single-beat reads.** `rlast` must already be high on the first beat. A design that set it only after a decrement would return an extra beat.
- **Bursts across the top word.** A design that did not wrap the index would write or read past the end of the store.
- **Rejected writes.** After each one the bench reads the words back. A design that gated only the response, and not the write enable, would corrupt the store.
- **Random stalls.** The bench holds `rready` and `bready` low for random periods. A design that dropped `rvalid` or `bvalid` early would lose a beat or a response.
- **Random byte strobes.** A design that ignored `wstrb` would overwrite bytes that should keep their old value.
- **Concurrent bursts.** Running a read and a write together exposes any shared state between the two machines.

// File: rtl/axi_burst_mem_pkg.sv
package axi_burst_mem_pkg;

  localparam logic [1:0] BURST_INCR  = 2'b01;
  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

  typedef enum logic {
    RD_ADDR,
    RD_DATA
  } rd_state_e;

  typedef enum logic [1:0] {
    WR_ADDR,
    WR_DATA,
    WR_RESP
  } wr_state_e;

endpackage

// File: rtl/abm_req_check.sv
module abm_req_check
  import axi_burst_mem_pkg::*;
#(
  parameter int OFFS = 2
) (
  input  logic [OFFS-1:0] addr_lo,
  input  logic [2:0]      size,
  input  logic [1:0]      burst,
  output logic            bad
);

  localparam logic [2:0] FULL_SIZE = 3'(OFFS);

  logic narrow, unaligned, not_incr;

  always_comb begin
    narrow    = (size != FULL_SIZE);
    unaligned = (addr_lo != '0);
    not_incr  = (burst != BURST_INCR);
    bad       = narrow | unaligned | not_incr;
  end

endmodule

// File: rtl/abm_store.sv
module abm_store #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic                clk,
  input  logic                we,
  input  logic [IDX_W-1:0]    widx,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W/8-1:0] wstrb,
  input  logic [IDX_W-1:0]    ridx,
  output logic [DATA_W-1:0]   rdata
);

  localparam int LANES = DATA_W / 8;
  localparam int WORDS = 2 ** IDX_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] lane_mem [WORDS];
    logic       lane_en;

    assign lane_en = we & wstrb[g];

    always_ff @(posedge clk) begin
      if (lane_en) begin
        lane_mem[widx] <= wdata[8*g +: 8];
      end
    end

    assign rdata[8*g +: 8] = lane_mem[ridx];
  end

endmodule

// File: rtl/abm_rd_fsm.sv
module abm_rd_fsm
  import axi_burst_mem_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arvalid,
  output logic             arready,
  input  logic [IDX_W-1:0] ar_idx,
  input  logic [LEN_W-1:0] arlen,
  input  logic             req_bad,
  output logic             rvalid,
  input  logic             rready,
  output logic             rlast,
  output logic [1:0]       rresp,
  output logic [IDX_W-1:0] ridx,
  output logic             bad_take
);

  localparam logic [IDX_W-1:0] IDX_ONE = 1;
  localparam logic [LEN_W-1:0] CNT_ONE = 1;

  rd_state_e        state_q, state_n;
  logic [LEN_W-1:0] cnt_q, cnt_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic             err_q, err_n;
  logic             ardy_q, ardy_n;
  logic             take_addr, take_beat;

  assign take_addr = arvalid & ardy_q;
  assign take_beat = (state_q == RD_DATA) & rready;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    idx_n   = idx_q;
    err_n   = err_q;
    unique case (state_q)
      RD_ADDR: begin
        if (take_addr) begin
          state_n = RD_DATA;
          cnt_n   = arlen;
          idx_n   = ar_idx;
          err_n   = req_bad;
        end
      end
      RD_DATA: begin
        if (take_beat) begin
          if (cnt_q == '0) begin
            state_n = RD_ADDR;
          end else begin
            cnt_n = cnt_q - CNT_ONE;
            idx_n = idx_q + IDX_ONE;
          end
        end
      end
      default: state_n = RD_ADDR;
    endcase
    ardy_n = (state_n == RD_ADDR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RD_ADDR;
      cnt_q   <= '0;
      idx_q   <= '0;
      err_q   <= 1'b0;
      ardy_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      idx_q   <= idx_n;
      err_q   <= err_n;
      ardy_q  <= ardy_n;
    end
  end

  assign arready  = ardy_q;
  assign rvalid   = (state_q == RD_DATA);
  assign rlast    = rvalid & (cnt_q == '0);
  assign rresp    = (rvalid & err_q) ? RESP_SLVERR : RESP_OKAY;
  assign ridx     = idx_q;
  assign bad_take = take_addr & req_bad;

  a_r2_ar_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (arvalid && arready) |=> (!arready && rvalid));

  a_r4_rvalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !rready) |=> (rvalid && $stable(rlast) && $stable(rresp)));

  a_r5_burst_end: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && rready && rlast) |=> (!rvalid && arready));

endmodule

// File: rtl/abm_wr_fsm.sv
module abm_wr_fsm
  import axi_burst_mem_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             awvalid,
  output logic             awready,
  input  logic [IDX_W-1:0] aw_idx,
  input  logic             req_bad,
  input  logic             wvalid,
  output logic             wready,
  input  logic             wlast,
  output logic             bvalid,
  input  logic             bready,
  output logic [1:0]       bresp,
  output logic             mem_we,
  output logic [IDX_W-1:0] widx,
  output logic             bad_take
);

  localparam logic [IDX_W-1:0] IDX_ONE = 1;

  wr_state_e        state_q, state_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic             err_q, err_n;
  logic             awrdy_q, awrdy_n;
  logic             take_addr, take_beat;

  assign take_addr = awvalid & awrdy_q;
  assign take_beat = (state_q == WR_DATA) & wvalid;

  always_comb begin
    state_n = state_q;
    idx_n   = idx_q;
    err_n   = err_q;
    unique case (state_q)
      WR_ADDR: begin
        if (take_addr) begin
          state_n = WR_DATA;
          idx_n   = aw_idx;
          err_n   = req_bad;
        end
      end
      WR_DATA: begin
        if (take_beat) begin
          if (wlast) begin
            state_n = WR_RESP;
          end else begin
            idx_n = idx_q + IDX_ONE;
          end
        end
      end
      WR_RESP: begin
        if (bready) begin
          state_n = WR_ADDR;
        end
      end
      default: state_n = WR_ADDR;
    endcase
    awrdy_n = (state_n == WR_ADDR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WR_ADDR;
      idx_q   <= '0;
      err_q   <= 1'b0;
      awrdy_q <= 1'b0;
    end else begin
      state_q <= state_n;
      idx_q   <= idx_n;
      err_q   <= err_n;
      awrdy_q <= awrdy_n;
    end
  end

  assign awready  = awrdy_q;
  assign wready   = (state_q == WR_DATA);
  assign bvalid   = (state_q == WR_RESP);
  assign bresp    = (bvalid & err_q) ? RESP_SLVERR : RESP_OKAY;
  assign mem_we   = take_beat & ~err_q;
  assign widx     = idx_q;
  assign bad_take = take_addr & req_bad;

  a_r1_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({awready, wready, bvalid}));

  a_r7_last_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (wvalid && wready && wlast) |=> (!wready && bvalid));

  a_r7_resp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && !bready) |=> (bvalid && $stable(bresp)));

endmodule

// File: rtl/axi_burst_mem.sv
module axi_burst_mem
  import axi_burst_mem_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                awvalid,
  output logic                awready,
  input  logic [ADDR_W-1:0]   awaddr,
  input  logic [2:0]          awsize,
  input  logic [1:0]          awburst,
  input  logic                wvalid,
  output logic                wready,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W/8-1:0] wstrb,
  input  logic                wlast,
  output logic                bvalid,
  input  logic                bready,
  output logic [1:0]          bresp,
  input  logic                arvalid,
  output logic                arready,
  input  logic [ADDR_W-1:0]   araddr,
  input  logic [LEN_W-1:0]    arlen,
  input  logic [2:0]          arsize,
  input  logic [1:0]          arburst,
  output logic                rvalid,
  input  logic                rready,
  output logic [DATA_W-1:0]   rdata,
  output logic [1:0]          rresp,
  output logic                rlast,
  output logic                req_err
);

  localparam int STRB_W = DATA_W / 8;
  localparam int OFFS   = $clog2(STRB_W);
  localparam int IDX_W  = ADDR_W - OFFS;

  logic             rd_bad, wr_bad;
  logic             rd_bad_take, wr_bad_take;
  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic             mem_we;
  logic [DATA_W-1:0] mem_rdata;
  logic             err_q, err_n;

  abm_req_check #(.OFFS(OFFS)) u_rd_check (
    .addr_lo (araddr[OFFS-1:0]),
    .size    (arsize),
    .burst   (arburst),
    .bad     (rd_bad)
  );

  abm_req_check #(.OFFS(OFFS)) u_wr_check (
    .addr_lo (awaddr[OFFS-1:0]),
    .size    (awsize),
    .burst   (awburst),
    .bad     (wr_bad)
  );

  abm_rd_fsm #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .arvalid  (arvalid),
    .arready  (arready),
    .ar_idx   (araddr[ADDR_W-1:OFFS]),
    .arlen    (arlen),
    .req_bad  (rd_bad),
    .rvalid   (rvalid),
    .rready   (rready),
    .rlast    (rlast),
    .rresp    (rresp),
    .ridx     (rd_idx),
    .bad_take (rd_bad_take)
  );

  abm_wr_fsm #(.IDX_W(IDX_W)) u_wr (
    .clk      (clk),
    .rst_n    (rst_n),
    .awvalid  (awvalid),
    .awready  (awready),
    .aw_idx   (awaddr[ADDR_W-1:OFFS]),
    .req_bad  (wr_bad),
    .wvalid   (wvalid),
    .wready   (wready),
    .wlast    (wlast),
    .bvalid   (bvalid),
    .bready   (bready),
    .bresp    (bresp),
    .mem_we   (mem_we),
    .widx     (wr_idx),
    .bad_take (wr_bad_take)
  );

  abm_store #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
    .clk   (clk),
    .we    (mem_we),
    .widx  (wr_idx),
    .wdata (wdata),
    .wstrb (wstrb),
    .ridx  (rd_idx),
    .rdata (mem_rdata)
  );

  assign rdata = (rresp == RESP_SLVERR) ? '0 : mem_rdata;

  always_comb begin
    err_n = err_q | rd_bad_take | wr_bad_take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_n;
    end
  end

  assign req_err = err_q;

  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |=> req_err);

endmodule

// File: tb/test_axi_burst_mem.sv
module test_axi_burst_mem;

  logic        clk, rst_n;
  logic        awvalid, awready, wvalid, wready, wlast, bvalid, bready;
  logic [7:0]  awaddr, araddr, arlen;
  logic [2:0]  awsize, arsize;
  logic [1:0]  awburst, arburst, bresp, rresp;
  logic [31:0] wdata, rdata;
  logic [3:0]  wstrb;
  logic        arvalid, arready, rvalid, rready, rlast, req_err;

  int n_cmp, n_bad;
  logic [31:0] model [64];

  axi_burst_mem i_axi_burst_mem (
    .clk(clk), .rst_n(rst_n),
    .awvalid(awvalid), .awready(awready), .awaddr(awaddr),
    .awsize(awsize), .awburst(awburst),
    .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb),
    .wlast(wlast), .bvalid(bvalid), .bready(bready), .bresp(bresp),
    .arvalid(arvalid), .arready(arready), .araddr(araddr), .arlen(arlen),
    .arsize(arsize), .arburst(arburst), .rvalid(rvalid), .rready(rready),
    .rdata(rdata), .rresp(rresp), .rlast(rlast), .req_err(req_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic bit is_bad(input logic [7:0] a, input logic [2:0] s,
                                input logic [1:0] b);
    return (s != 3'd2) || (b != 2'b01) || (a[1:0] != 2'b00);
  endfunction

  task automatic axi_wr(input logic [7:0] a, input int beats,
                        input logic [2:0] s, input logic [1:0] b,
                        input bit rnd_strb, input string rq);
    bit bad = is_bad(a, s, b);
    int base = int'(a[7:2]);
    @(negedge clk);
    awvalid = 1'b1; awaddr = a; awsize = s; awburst = b;
    while (!awready) @(negedge clk);
    @(negedge clk);
    awvalid = 1'b0;
    check("R2", "awready after aw handshake", {31'd0, awready}, 32'd0);
    for (int k = 0; k < beats; k++) begin
      repeat ($urandom % 3) @(negedge clk);
      wvalid = 1'b1;
      wdata  = $urandom;
      wstrb  = rnd_strb ? 4'($urandom) : 4'hf;
      wlast  = (k == beats - 1);
      while (!wready) @(negedge clk);
      if (!bad) begin
        for (int l = 0; l < 4; l++)
          if (wstrb[l]) model[(base + k) % 64][8*l +: 8] = wdata[8*l +: 8];
      end
      @(negedge clk);
      wvalid = 1'b0; wlast = 1'b0;
    end
    check("R7", "wready after wlast", {31'd0, wready}, 32'd0);
    check("R7", "bvalid after wlast", {31'd0, bvalid}, 32'd1);
    repeat ($urandom % 3) begin
      @(negedge clk);
      check("R7", "bvalid held", {31'd0, bvalid}, 32'd1);
    end
    bready = 1'b1;
    check(rq, "bresp", {30'd0, bresp}, bad ? 32'd2 : 32'd0);
    @(negedge clk);
    bready = 1'b0;
    check("R7", "bvalid after b handshake", {31'd0, bvalid}, 32'd0);
    check("R7", "awready back", {31'd0, awready}, 32'd1);
  endtask

  task automatic axi_rd(input logic [7:0] a, input int beats,
                        input logic [2:0] s, input logic [1:0] b,
                        input string rq);
    bit bad = is_bad(a, s, b);
    int base = int'(a[7:2]);
    @(negedge clk);
    arvalid = 1'b1; araddr = a; arlen = 8'(beats - 1);
    arsize = s; arburst = b;
    while (!arready) @(negedge clk);
    @(negedge clk);
    arvalid = 1'b0;
    check("R2", "arready after ar handshake", {31'd0, arready}, 32'd0);
    check("R2", "rvalid after ar handshake", {31'd0, rvalid}, 32'd1);
    for (int k = 0; k < beats; k++) begin
      repeat ($urandom % 3) begin
        @(negedge clk);
        check("R4", "rvalid held", {31'd0, rvalid}, 32'd1);
      end
      rready = 1'b1;
      check("R3", "rlast", {31'd0, rlast}, (k == beats - 1) ? 32'd1 : 32'd0);
      check(rq, "rdata", rdata, bad ? 32'd0 : model[(base + k) % 64]);
      check(rq, "rresp", {30'd0, rresp}, bad ? 32'd2 : 32'd0);
      @(negedge clk);
      rready = 1'b0;
    end
    check("R5", "rvalid after last", {31'd0, rvalid}, 32'd0);
    check("R5", "arready back", {31'd0, arready}, 32'd1);
  endtask

  task automatic reset_checks;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1", "ready/valid in reset",
          {26'd0, arready, awready, rvalid, wready, bvalid, req_err}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "arready after reset", {31'd0, arready}, 32'd1);
    check("R1", "awready after reset", {31'd0, awready}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    n_cmp = 0; n_bad = 0;
    void'($urandom(32'd20240611));
    awvalid = 0; awaddr = 0; awsize = 0; awburst = 0;
    wvalid = 0; wdata = 0; wstrb = 0; wlast = 0; bready = 0;
    arvalid = 0; araddr = 0; arlen = 0; arsize = 0; arburst = 0; rready = 0;
    rst_n = 1'b0;
    reset_checks();

    axi_wr(8'h00, 64, 3'd2, 2'b01, 1'b0, "R6");
    axi_rd(8'h00, 64, 3'd2, 2'b01, "R3");
    axi_rd(8'h14, 1, 3'd2, 2'b01, "R3");

    for (int it = 0; it < 24; it++) begin
      logic [7:0] ad = {6'($urandom), 2'b00};
      int nb = 1 + int'($urandom % 8);
      if ($urandom % 2) axi_wr(ad, nb, 3'd2, 2'b01, 1'b1, "R6");
      else              axi_rd(ad, nb, 3'd2, 2'b01, "R3");
    end

    // wrap across the top word
    axi_wr(8'hFC, 3, 3'd2, 2'b01, 1'b1, "R6");
    axi_rd(8'hF8, 4, 3'd2, 2'b01, "R3");
    check("R11", "req_err before any reject", {31'd0, req_err}, 32'd0);

    axi_rd(8'h10, 2, 3'd1, 2'b01, "R8");
    check("R11", "req_err after narrow read", {31'd0, req_err}, 32'd1);
    axi_wr(8'h20, 2, 3'd1, 2'b01, 1'b0, "R8");
    axi_rd(8'h20, 2, 3'd2, 2'b01, "R8");
    axi_wr(8'h22, 2, 3'd2, 2'b01, 1'b0, "R9");
    axi_rd(8'h20, 3, 3'd2, 2'b01, "R9");
    axi_rd(8'h31, 1, 3'd2, 2'b01, "R9");
    axi_wr(8'h40, 2, 3'd2, 2'b10, 1'b0, "R10");
    axi_wr(8'h48, 2, 3'd2, 2'b00, 1'b0, "R10");
    axi_rd(8'h40, 4, 3'd2, 2'b01, "R10");
    axi_rd(8'h40, 2, 3'd2, 2'b00, "R10");

    fork
      axi_wr(8'h60, 8, 3'd2, 2'b01, 1'b1, "R12");
      axi_rd(8'hA0, 8, 3'd2, 2'b01, "R12");
    join
    axi_rd(8'h60, 8, 3'd2, 2'b01, "R12");
    check("R11", "req_err after legal traffic", {31'd0, req_err}, 32'd1);

    reset_checks();
    check("R11", "req_err cleared by reset", {31'd0, req_err}, 32'd0);
    axi_rd(8'h00, 4, 3'd2, 2'b01, "R3");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule